// File: doc/BRIEF.md
# Multi-Mode Addressable Bit Latch

This block is a small parallel-out register of `WIDTH` bits. On each clock edge it takes one serial data bit and a binary bit index. Two active-low controls choose what happens to the register. It can write the addressed bit and leave the other bits alone. It can hold every bit. It can act as a one-hot demultiplexer that routes the data bit to the addressed output and drives every other output low. It can also clear every bit. Typical uses are serial-to-parallel assembly of flags, a working register that is built up one bit at a time, and an active-high address decoder.

This variant samples all of its inputs on a system clock, so it synthesizes to flip-flops and infers no latches. The outputs come straight from the storage flops, so what the outputs show and what is stored are always the same bits. A demultiplexer cycle therefore overwrites the stored contents: the addressed bit keeps the data value, and every other bit is left at zero. A synchronous active-high reset zeroes the register and takes priority over every mode.

Top module: `addr_bit_latch`

## Requirements
- R1: When `rst` is high at a rising clock edge, every bit of `q` is 0 after that edge, whatever the other inputs are.
- R2: Write mode (`clr_n`=1, `en_n`=0): after the edge, bit `sel` of `q` equals `din`, and every other bit keeps its previous value.
- R3: Hold mode (`clr_n`=1, `en_n`=1): `q` does not change, for any value of `din` and `sel`.
- R4: Demultiplexer mode (`clr_n`=0, `en_n`=0): after the edge, bit `sel` of `q` equals `din` and every other bit is 0.
- R5: Clear mode (`clr_n`=0, `en_n`=1): after the edge, every bit of `q` is 0, whatever `din` and `sel` are.
- R6: `sel` is an unsigned binary index, with its top bit as the most significant bit. For example, `sel`=3'b101 with `WIDTH`=8 addresses `q[5]` and no other bit.
- R7: The pattern left by a demultiplexer cycle becomes the stored contents. After a following hold cycle, `q` still shows `din` at the last addressed bit and zeros elsewhere. The contents from before the demultiplexer cycle do not return.
- R8: In write mode the bit index may change every cycle. Back-to-back write cycles to different addresses each update their own bit, so `WIDTH` consecutive writes can load an entire word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; zeroes the register |
| din | input | 1 | Serial data bit |
| sel | input | SEL_W | Binary index of the addressed bit |
| en_n | input | 1 | Active-low enable; low allows a write or demultiplex |
| clr_n | input | 1 | Active-low clear; low selects demultiplexer or clear mode |
| q | output | WIDTH | Registered parallel outputs |

## Verification
Directed walks write alternating ones and zeros across all indices. These walks separate a correct index decode from swapped or shifted select bits, and they show whether a single write disturbs its neighbours. Hold and clear cycles are driven with changing `din` and `sel`, so that a path which wrongly decodes the address in those modes becomes visible. A filled register followed by a demultiplexer cycle and then a hold cycle tells a design whose demultiplexer only masks the outputs apart from one that overwrites storage. A long random mix of all four modes and occasional resets is compared, edge by edge, with a model computed in the bench. This mix covers mode changes in the middle of a sequence.

// File: rtl/abl_pkg.sv
package abl_pkg;

  // Mode encoding is {clr_n, en_n}
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_HOLD  = 2'b11
  } abl_mode_t;

endpackage

// File: rtl/abl_mode_dec.sv
module abl_mode_dec
  import abl_pkg::*;
(
  input  logic      clr_n,
  input  logic      en_n,
  output abl_mode_t mode
);

  always_comb begin
    unique case ({clr_n, en_n})
      2'b00:   mode = MODE_DEMUX;
      2'b01:   mode = MODE_CLEAR;
      2'b10:   mode = MODE_WRITE;
      default: mode = MODE_HOLD;
    endcase
  end

endmodule

// File: rtl/abl_sel_dec.sv
module abl_sel_dec #(
  parameter int WIDTH = 8,
  parameter int SEL_W = $clog2(WIDTH)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] hit
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_hit
    assign hit[i] = (sel == SEL_W'(i));
  end

endmodule

// File: rtl/abl_bit_cell.sv
module abl_bit_cell
  import abl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  abl_mode_t mode,
  input  logic      hit,
  input  logic      din,
  output logic      q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      unique case (mode)
        MODE_WRITE: if (hit) q <= din;
        MODE_HOLD:  q <= q;
        MODE_DEMUX: q <= hit & din;
        default:    q <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import abl_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SEL_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic             en_n,
  input  logic             clr_n,
  output logic [WIDTH-1:0] q
);

  abl_mode_t        mode;
  logic [WIDTH-1:0] hit;

  abl_mode_dec u_mode (
    .clr_n (clr_n),
    .en_n  (en_n),
    .mode  (mode)
  );

  abl_sel_dec #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_sel (
    .sel (sel),
    .hit (hit)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    abl_bit_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .hit  (hit[i]),
      .din  (din),
      .q    (q[i])
    );
  end

endmodule

// File: rtl/abl_chk.sv
module abl_chk #(
  parameter int WIDTH = 8,
  parameter int SEL_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             din,
  input logic [SEL_W-1:0] sel,
  input logic             en_n,
  input logic             clr_n,
  input logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] sel_mask;
  logic [WIDTH-1:0] din_at_sel;
  assign sel_mask   = {{(WIDTH-1){1'b0}}, 1'b1} << sel;
  assign din_at_sel = din ? sel_mask : '0;

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (q == '0));

  // R2
  write_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !en_n) |=> (q[$past(sel)] == $past(din)));

  // R8
  write_others_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !en_n) |=> (((q ^ $past(q)) & ~$past(sel_mask)) == '0));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && en_n) |=> $stable(q));

  // R4
  demux_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !en_n) |=> (q == $past(din_at_sel)));

  // R4
  demux_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !en_n) |=> $onehot0(q));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && en_n) |=> (q == '0));

endmodule

bind addr_bit_latch abl_chk #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .din   (din),
  .sel   (sel),
  .en_n  (en_n),
  .clr_n (clr_n),
  .q     (q)
);

// File: tb/tb_addr_bit_latch.sv
`timescale 1ns/1ps
module tb_addr_bit_latch;

  localparam int WIDTH = 8;
  localparam int SEL_W = $clog2(WIDTH);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             din = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic             en_n = 1'b1;
  logic             clr_n = 1'b1;
  logic [WIDTH-1:0] q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [WIDTH-1:0] mdl = '0;

  always #2 clk = ~clk;

  addr_bit_latch #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rst(rst), .din(din), .sel(sel),
    .en_n(en_n), .clr_n(clr_n), .q(q)
  );

  function automatic logic [WIDTH-1:0] next_val(
    input logic [WIDTH-1:0] cur, input logic r, input logic d,
    input logic [SEL_W-1:0] s, input logic c_n, input logic e_n);
    logic [WIDTH-1:0] nv;
    nv = cur;
    if (r) nv = '0;
    else if (c_n && !e_n) nv[s] = d;
    else if (!c_n && !e_n) begin nv = '0; nv[s] = d; end
    else if (!c_n && e_n) nv = '0;
    return nv;
  endfunction

  task automatic check(input string req, input logic [WIDTH-1:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected=%h", req, q, exp);
    end
  endtask

  // Drive at falling edge, let one rising edge pass, compare at next falling edge
  task automatic step(input string req, input logic r, input logic d,
                      input logic [SEL_W-1:0] s, input logic c_n, input logic e_n);
    rst = r; din = d; sel = s; clr_n = c_n; en_n = e_n;
    mdl = next_val(mdl, r, d, s, c_n, e_n);
    @(negedge clk);
    check(req, mdl);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: q=%h expected=done", q);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    @(negedge clk);
    step("R1 reset", 1'b1, 1'b1, 3'd3, 1'b1, 1'b0);
    // R8: fill word with alternating pattern, one bit per cycle
    for (int i = 0; i < WIDTH; i++) step("R8 fill", 1'b0, i[0], SEL_W'(i), 1'b1, 1'b0);
    check("R8 word", 8'haa);
    // R2: rewrite one bit, neighbours untouched
    step("R2 write", 1'b0, 1'b1, 3'd0, 1'b1, 1'b0);
    check("R2 value", 8'hab);
    // R3: hold with churning inputs
    for (int i = 0; i < 6; i++)
      step("R3 hold", 1'b0, i[0], SEL_W'($urandom), 1'b1, 1'b1);
    check("R3 value", 8'hab);
    // R6: index ordering
    step("R5 clear", 1'b0, 1'b1, 3'd7, 1'b0, 1'b1);
    check("R5 value", 8'h00);
    step("R6 index", 1'b0, 1'b1, 3'b101, 1'b1, 1'b0);
    check("R6 value", 8'h20);
    step("R6 index msb", 1'b0, 1'b1, 3'b100, 1'b1, 1'b0);
    check("R6 value2", 8'h30);
    // R4: demultiplexer for each address, din high and low
    for (int i = 0; i < WIDTH; i++) begin
      step("R4 demux", 1'b0, 1'b1, SEL_W'(i), 1'b0, 1'b0);
      check("R4 onehot", 8'(1 << i));
    end
    step("R4 demux zero", 1'b0, 1'b0, 3'd2, 1'b0, 1'b0);
    check("R4 value", 8'h00);
    // R7: fill, demux, hold
    for (int i = 0; i < WIDTH; i++) step("R8 fill ones", 1'b0, 1'b1, SEL_W'(i), 1'b1, 1'b0);
    step("R4 demux after fill", 1'b0, 1'b1, 3'd6, 1'b0, 1'b0);
    step("R7 hold after demux", 1'b0, 1'b0, 3'd1, 1'b1, 1'b1);
    check("R7 value", 8'h40);
    // R1: reset overrides write
    step("R1 reset over write", 1'b1, 1'b1, 3'd6, 1'b1, 1'b0);
    check("R1 value", 8'h00);
    // Random mix with mode switches
    for (int i = 0; i < 600; i++) begin
      logic r, c, e;
      string tag;
      r = ($urandom % 40) == 0;
      c = ($urandom % 4) != 0;
      e = $urandom % 2;
      if (r) tag = "R1 random";
      else if (c && !e) tag = "R2 random";
      else if (c && e) tag = "R3 random";
      else if (!e) tag = "R4 random";
      else tag = "R5 random";
      step(tag, r, 1'($urandom), SEL_W'($urandom), c, e);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule